// File: doc/BRIEF.md
# Memory Copy DMA Engine

This block copies a contiguous run of 32-bit words from one memory region to another. Software sets it up through a small configuration port. That port uses a level request/acknowledge handshake. The configuration holds a source address, a destination address and a word count, and a fourth location launches the copy. The engine then works on its own through a memory master port. For each word it reads from the source, writes the word to the destination, and steps both addresses by one word. The memory side may take any number of cycles to acknowledge.

After the last word is written, the engine raises a completion interrupt. The interrupt stays high until a dedicated clear input is pulsed. While a copy runs, configuration writes are acknowledged but have no effect, and reads return what is held. Reset is synchronous and active high.

Top module: `dma_copy_engine`

## Requirements
- R1: A synchronous reset (`rst` high) clears all four configuration registers to zero and drives `cfg_ack`, `mem_req` and `irq_done` low, including when it arrives in the middle of a copy.
- R2: The full configuration address selects a register: 0x0 is the source address, 0x4 is the destination address, 0x8 is the word count, and 0xC is the launch register. A write followed by a read of the same address returns the written value.
- R3: An access is accepted when `cfg_req` is high and the port is idle. `cfg_ack` goes high at the next clock edge and stays high while `cfg_req` stays high. It falls at the edge after `cfg_req` drops. A held request is performed only once, even if its write data changes.
- R4: A write to 0xC while idle starts a copy that uses the source, destination and count held at that moment. The first memory request is a read of the source address.
- R5: A read is signalled by `mem_req`=1 with `mem_rd`=1. The word on `mem_rdata` is captured in the cycle where `mem_ack` is high.
- R6: A write is signalled by `mem_req`=1 with `mem_rd`=0. It carries the word just read on `mem_wdata`. `mem_addr`, `mem_rd` and `mem_wdata` stay stable until `mem_ack`.
- R7: Words are processed as read-then-write pairs, with one request outstanding at a time. `mem_req` is low for the cycle after every acknowledge. Read addresses step source+4k and write addresses step destination+4k, with 32-bit wrap-around.
- R8: `irq_done` rises at the clock edge that takes the acknowledge of the last write, and not before. It then stays high until `irq_clear` is sampled high.
- R9: A launch with a word count of zero sets `irq_done` at the edge that accepts the launch write. No memory request is issued.
- R10: While a copy is running, configuration writes (including writes to 0xC) are acknowledged but change no register and start nothing. Reads return the held values.
- R11: Accesses to any other address, including unaligned offsets, are acknowledged. Writes to them are dropped and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_req | input | 1 | Configuration access request (level) |
| cfg_rd | input | 1 | 1 = read, 0 = write |
| cfg_addr | input | 32 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, valid with `cfg_ack` |
| cfg_ack | output | 1 | Configuration acknowledge (level) |
| irq_done | output | 1 | Sticky copy-complete interrupt |
| irq_clear | input | 1 | Clears `irq_done` |
| mem_req | output | 1 | Memory request (level) |
| mem_rd | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The hardest state to reach is a configuration access that lands while a copy is still in flight. Only that window shows whether a busy write is really ignored. The bench runs a five-word copy against a memory that waits three cycles before each acknowledge. Right after the launch it rewrites the source address and writes to the launch register again. It then reads the source register back and counts the words that reach memory. A reset applied halfway through a slow copy is driven the same way, to show that the master port and the interrupt drop at once.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

  // Configuration register byte offsets (decoded against the full address)
  localparam logic [3:0] OFS_SRC = 4'h0;
  localparam logic [3:0] OFS_DST = 4'h4;
  localparam logic [3:0] OFS_LEN = 4'h8;
  localparam logic [3:0] OFS_GO  = 4'hC;

  typedef enum logic {
    CF_IDLE,
    CF_ACK
  } cfg_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD,
    SQ_PREP_W,
    SQ_WR,
    SQ_PREP_R
  } seq_state_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_copy_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_req,
  input  logic          cfg_rd,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          cfg_ack,
  input  logic          busy_i,
  output logic          start_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] len_o
);

  cfg_state_t    st;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] len_q, go_q;
  logic          hit_src, hit_dst, hit_len, hit_go;
  logic          accept, wr_ok;
  logic [DW-1:0] rd_mux;

  assign hit_src = (cfg_addr == AW'(OFS_SRC));
  assign hit_dst = (cfg_addr == AW'(OFS_DST));
  assign hit_len = (cfg_addr == AW'(OFS_LEN));
  assign hit_go  = (cfg_addr == AW'(OFS_GO));

  assign accept  = (st == CF_IDLE) && cfg_req;
  assign wr_ok   = accept && !cfg_rd && !busy_i;
  assign start_o = wr_ok && hit_go;

  always_comb begin
    rd_mux = '0;
    if (hit_src)      rd_mux = DW'(src_q);
    else if (hit_dst) rd_mux = DW'(dst_q);
    else if (hit_len) rd_mux = len_q;
    else if (hit_go)  rd_mux = go_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CF_IDLE;
      cfg_ack   <= 1'b0;
      cfg_rdata <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      len_q     <= '0;
      go_q      <= '0;
    end else begin
      case (st)
        CF_IDLE: begin
          if (cfg_req) begin
            st      <= CF_ACK;
            cfg_ack <= 1'b1;
            if (cfg_rd) cfg_rdata <= rd_mux;
          end
        end
        CF_ACK: begin
          if (!cfg_req) begin
            st      <= CF_IDLE;
            cfg_ack <= 1'b0;
          end
        end
        default: st <= CF_IDLE;
      endcase
      if (wr_ok) begin
        if (hit_src) src_q <= AW'(cfg_wdata);
        if (hit_dst) dst_q <= AW'(cfg_wdata);
        if (hit_len) len_q <= cfg_wdata;
        if (hit_go)  go_q  <= cfg_wdata;
      end
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign len_o = len_q;

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_ack && cfg_req |=> cfg_ack); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cfg_ack && !cfg_req |=> !cfg_ack); // R3
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(src_q) && $stable(dst_q) && $stable(len_q)); // R10

endmodule

// File: rtl/dma_copy_seq.sv
module dma_copy_seq
  import dma_copy_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam int            STEP   = DW / 8;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  seq_state_t    st;
  logic [AW-1:0] src_c, dst_c;
  logic [DW-1:0] left;
  logic          last_word;

  assign last_word = (left == DW'(1));
  assign busy_o    = (st != SQ_IDLE);
  assign done_o    = ((st == SQ_IDLE) && start_i && (len_i == '0)) ||
                     ((st == SQ_WR) && mem_ack && last_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      src_c     <= '0;
      dst_c     <= '0;
      left      <= '0;
      mem_req   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start_i && (len_i != '0)) begin
            src_c    <= src_i;
            dst_c    <= dst_i;
            left     <= len_i;
            mem_req  <= 1'b1;
            mem_rd   <= 1'b1;
            mem_addr <= src_i;
            st       <= SQ_RD;
          end
        end
        SQ_RD: begin
          if (mem_ack) begin
            mem_wdata <= mem_rdata;
            mem_req   <= 1'b0;
            st        <= SQ_PREP_W;
          end
        end
        SQ_PREP_W: begin
          mem_req  <= 1'b1;
          mem_rd   <= 1'b0;
          mem_addr <= dst_c;
          st       <= SQ_WR;
        end
        SQ_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            src_c   <= src_c + STEP_A;
            dst_c   <= dst_c + STEP_A;
            left    <= left - DW'(1);
            st      <= last_word ? SQ_IDLE : SQ_PREP_R;
          end
        end
        SQ_PREP_R: begin
          mem_req  <= 1'b1;
          mem_rd   <= 1'b1;
          mem_addr <= src_c;
          st       <= SQ_RD;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) &&
                            $stable(mem_rd) && $stable(mem_wdata)); // R6
  AST_MEM_GAP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req); // R7
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && !mem_rd |-> $past(mem_rd)); // R7

endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_o && !clr_i |=> irq_o); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(set_i)); // R8

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_req,
  input  logic          cfg_rd,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          cfg_ack,
  output logic          irq_done,
  input  logic          irq_clear,
  output logic          mem_req,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  logic          busy, start, done;
  logic [AW-1:0] src_v, dst_v;
  logic [DW-1:0] len_v;

  dma_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_req   (cfg_req),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_ack   (cfg_ack),
    .busy_i    (busy),
    .start_o   (start),
    .src_o     (src_v),
    .dst_o     (dst_v),
    .len_o     (len_v)
  );

  dma_copy_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .src_i     (src_v),
    .dst_i     (dst_v),
    .len_i     (len_v),
    .busy_o    (busy),
    .done_o    (done),
    .mem_req   (mem_req),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  dma_irq_flag u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (done),
    .clr_i (irq_clear),
    .irq_o (irq_done)
  );

  AST_ZERO_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
    start && (len_v == '0) && !mem_req |=> !mem_req); // R9

endmodule

// File: tb/tb_dma_copy_engine.sv
module tb_dma_copy_engine;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_req, cfg_rd;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic        cfg_ack, irq_done, irq_clear;
  logic        mem_req, mem_rd, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk; // 50 MHz

  dma_copy_engine dut (
    .clk(clk), .rst(rst),
    .cfg_req(cfg_req), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
    .irq_done(irq_done), .irq_clear(irq_clear),
    .mem_req(mem_req), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // {source, destination, words, ack latency}
  localparam logic [31:0] JOBS [4][4] = '{
    '{32'h0000_1000, 32'h0000_8000, 32'd1, 32'd0},
    '{32'h0001_0040, 32'h0002_0000, 32'd3, 32'd0},
    '{32'hFFFF_FFF8, 32'h0000_0100, 32'd4, 32'd1},
    '{32'h4000_0000, 32'h2000_0000, 32'd2, 32'd2}
  };

  int total = 0, bad = 0;
  int rd_cnt, wr_cnt, traffic, cur_lat;
  logic [31:0] exp_src, exp_dst, exp_len;
  logic [31:0] rv;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_rd = 1'b0; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    while (!cfg_ack) @(negedge clk);
    cfg_req = 1'b0;
    @(negedge clk);
    while (cfg_ack) @(negedge clk);
  endtask

  task automatic cfg_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    while (!cfg_ack) @(negedge clk);
    d = cfg_rdata;
    cfg_req = 1'b0;
    @(negedge clk);
    while (cfg_ack) @(negedge clk);
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq_done && n < 3000) begin @(negedge clk); n++; end
    check(irq_done, "R8 irq after copy", 32'(irq_done), 32'd1);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  task automatic arm(input logic [31:0] s, input logic [31:0] d,
                     input logic [31:0] n, input int lat);
    exp_src = s; exp_dst = d; exp_len = n; cur_lat = lat;
    rd_cnt = 0; wr_cnt = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Memory responder: acknowledges each request after cur_lat cycles
  initial begin
    int  wcnt = 0;
    bit  seen = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 1'b0; wcnt = 0; seen = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0; wcnt = 0; seen = 0;
      end else if (mem_req) begin
        if (!seen) begin
          seen = 1; traffic++;
          if (mem_rd) begin
            check(rd_cnt == wr_cnt, "R7 read follows write", 32'(rd_cnt), 32'(wr_cnt));
            check(mem_addr == exp_src + 32'(4*rd_cnt), "R4 R5 read address",
                  mem_addr, exp_src + 32'(4*rd_cnt));
          end else begin
            check(rd_cnt == wr_cnt + 1, "R7 write follows read", 32'(rd_cnt), 32'(wr_cnt + 1));
            check(mem_addr == exp_dst + 32'(4*wr_cnt), "R7 write address",
                  mem_addr, exp_dst + 32'(4*wr_cnt));
            check(mem_wdata == pat(exp_src + 32'(4*wr_cnt)), "R6 write data",
                  mem_wdata, pat(exp_src + 32'(4*wr_cnt)));
          end
        end
        if (wcnt >= cur_lat) begin
          mem_ack = 1'b1;
          if (mem_rd) begin
            mem_rdata = pat(mem_addr);
            rd_cnt++;
          end else begin
            if (wr_cnt + 1 == int'(exp_len))
              check(!irq_done, "R8 irq not early", 32'(irq_done), 32'd0);
            wr_cnt++;
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    traffic = 0; cur_lat = 0;
    arm(0, 0, 0, 0);
    rst = 1'b1; cfg_req = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    irq_clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cfg_ack && !mem_req && !irq_done, "R1 outputs in reset",
          {29'd0, cfg_ack, mem_req, irq_done}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cfg_read(32'(4*i), rv);
      check(rv == 32'd0, "R1 register cleared", rv, 32'd0);
    end

    // R2 register map read-back
    cfg_write(32'h0, 32'h1111_2220);
    cfg_write(32'h4, 32'h3333_4440);
    cfg_write(32'h8, 32'd0);
    cfg_read(32'h0, rv); check(rv == 32'h1111_2220, "R2 source readback", rv, 32'h1111_2220);
    cfg_read(32'h4, rv); check(rv == 32'h3333_4440, "R2 destination readback", rv, 32'h3333_4440);
    cfg_read(32'h8, rv); check(rv == 32'd0, "R2 count readback", rv, 32'd0);

    // R11 unmapped and unaligned addresses
    cfg_write(32'h10, 32'hBAD0_BAD0);
    cfg_write(32'h1, 32'hBAD1_BAD1);
    cfg_read(32'h10, rv); check(rv == 32'd0, "R11 unmapped read", rv, 32'd0);
    cfg_read(32'h2, rv);  check(rv == 32'd0, "R11 unaligned read", rv, 32'd0);
    cfg_read(32'h0, rv);  check(rv == 32'h1111_2220, "R11 source untouched", rv, 32'h1111_2220);

    // R3 handshake: held request is performed once
    @(negedge clk);
    cfg_req = 1'b1; cfg_rd = 1'b0; cfg_addr = 32'h4; cfg_wdata = 32'hAAAA_0000;
    @(negedge clk);
    check(cfg_ack, "R3 ack one cycle after request", 32'(cfg_ack), 32'd1);
    cfg_wdata = 32'hBBBB_0000;
    repeat (3) @(negedge clk);
    check(cfg_ack, "R3 ack held with request", 32'(cfg_ack), 32'd1);
    cfg_req = 1'b0;
    @(negedge clk);
    check(!cfg_ack, "R3 ack drops after request", 32'(cfg_ack), 32'd0);
    cfg_read(32'h4, rv);
    check(rv == 32'hAAAA_0000, "R3 single write per request", rv, 32'hAAAA_0000);

    // R9 zero-length launch
    traffic = 0;
    cfg_write(32'h8, 32'd0);
    cfg_write(32'hC, 32'h0000_0001);
    check(irq_done, "R9 irq on zero length", 32'(irq_done), 32'd1);
    repeat (4) @(negedge clk);
    check(traffic == 0, "R9 no memory traffic", 32'(traffic), 32'd0);
    cfg_read(32'hC, rv); check(rv == 32'h1, "R2 launch readback", rv, 32'h1);
    clear_irq();
    check(!irq_done, "R8 irq cleared", 32'(irq_done), 32'd0);

    // Table-driven copies
    for (int j = 0; j < 4; j++) begin
      arm(JOBS[j][0], JOBS[j][1], JOBS[j][2], int'(JOBS[j][3]));
      cfg_write(32'h0, JOBS[j][0]);
      cfg_write(32'h4, JOBS[j][1]);
      cfg_write(32'h8, JOBS[j][2]);
      cfg_write(32'hC, 32'hFFFF_FFFF);
      wait_irq();
      check(wr_cnt == int'(JOBS[j][2]), "R8 words written", 32'(wr_cnt), JOBS[j][2]);
      check(rd_cnt == int'(JOBS[j][2]), "R7 words read", 32'(rd_cnt), JOBS[j][2]);
      repeat (5) @(negedge clk);
      check(irq_done, "R8 irq sticky", 32'(irq_done), 32'd1);
      clear_irq();
      check(!irq_done, "R8 irq cleared", 32'(irq_done), 32'd0);
    end

    // R10 writes during a copy are ignored
    arm(32'h0000_2000, 32'h0000_9000, 32'd5, 3);
    cfg_write(32'h0, 32'h0000_2000);
    cfg_write(32'h4, 32'h0000_9000);
    cfg_write(32'h8, 32'd5);
    cfg_write(32'hC, 32'h0000_0007);
    cfg_write(32'h0, 32'hDEAD_0000);
    cfg_write(32'h8, 32'd1);
    cfg_write(32'hC, 32'h0000_0009);
    check(!irq_done, "R10 still busy", 32'(irq_done), 32'd0);
    cfg_read(32'h0, rv); check(rv == 32'h0000_2000, "R10 source kept", rv, 32'h0000_2000);
    cfg_read(32'h8, rv); check(rv == 32'd5, "R10 count kept", rv, 32'd5);
    cfg_read(32'hC, rv); check(rv == 32'h7, "R10 launch kept", rv, 32'h7);
    wait_irq();
    repeat (10) @(negedge clk);
    check(wr_cnt == 5, "R10 no second copy", 32'(wr_cnt), 32'd5);
    clear_irq();

    // R1 reset in the middle of a copy
    arm(32'h0000_3000, 32'h0000_A000, 32'd4, 8);
    cfg_write(32'h0, 32'h0000_3000);
    cfg_write(32'h4, 32'h0000_A000);
    cfg_write(32'h8, 32'd4);
    cfg_write(32'hC, 32'h1);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req && !irq_done && !cfg_ack, "R1 mid-copy reset outputs",
          {29'd0, cfg_ack, mem_req, irq_done}, 32'd0);
    rst = 1'b0;
    cfg_read(32'h0, rv); check(rv == 32'd0, "R1 source cleared", rv, 32'd0);
    cfg_read(32'h8, rv); check(rv == 32'd0, "R1 count cleared", rv, 32'd0);
    repeat (10) @(negedge clk);
    check(!mem_req, "R1 engine idle after reset", 32'(mem_req), 32'd0);

    finish_run();
  end

endmodule